// File: doc/BRIEF.md
# Condition-Field Predicate Mask Builder

This block turns a vector condition test into a per-element predicate mask. After a start pulse it walks the element indices in ascending order, from 0 to the vector length minus one. For each element it reads one 4-bit condition field from an external condition register file. It picks one bit of that field, optionally inverts it, and stores the result at the element's position in the mask. The mask is built one element at a time, with one field read per element.

The register file has a one-cycle read latency and is addressed by a one-hot read-enable. Element `i` addresses field `i + BASE_FIELD`, and that field's enable sits at bit `NUM_FIELDS-1-(i+BASE_FIELD)`. Field numbering therefore runs from the top enable bit downward. When every element is done, the finished mask is offered under a valid/ready handshake. The block returns to idle once the mask is taken.

Top module: `cr_pred_mask_builder`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy_o`, `mask_valid_o`, `cr_rd_en_o` and `mask_o` are all zero.
- R2: A start pulse is accepted only while `busy_o` is low, and `busy_o` goes high on the next cycle. A start pulse, or a change of selector or length, while busy has no effect on the reads, the mask or the timing of the run in progress.
- R3: Element `i` issues exactly one read, in the order i = 0, 1, ... The read-enable is one-hot with only bit `NUM_FIELDS-1-(i+BASE_FIELD)` set (default BASE_FIELD = 0, so element 0 drives bit 7). A cycle with a read-enable is always followed by a cycle without one.
- R4: The field data is taken in the cycle right after the read-enable cycle.
- R5: The selector picks field bit `cond_sel_i[2:1]`. Codes 0 and 1 (LT/GE) use bit 0, codes 2 and 3 (GT/LE) use bit 1, codes 4 and 5 (EQ/NE) use bit 2, and codes 6 and 7 (SO/NS) use bit 3.
- R6: Mask bit `i` is the selected bit XORed with `cond_sel_i[0]`. An even code stores the bit as read and an odd code stores it inverted, so each pair of codes yields complementary masks.
- R7: Mask bits at index greater than or equal to the effective length are 0.
- R8: The effective length is `vec_len_i` clamped to the range 1 to `NUM_FIELDS-BASE_FIELD`. A value of 0 acts as 1, and larger values act as the maximum.
- R9: `mask_valid_o` stays high with `mask_o` unchanged until `mask_ready_i` is sampled high. In the next cycle `busy_o` and `mask_valid_o` are low.
- R10: `mask_valid_o` rises exactly 2×(effective length) cycles after the clock edge that accepted the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, used only while idle |
| cond_sel_i | input | 3 | Condition selector (0 LT, 1 GE, 2 GT, 3 LE, 4 EQ, 5 NE, 6 SO, 7 NS) |
| vec_len_i | input | 4 | Vector length, clamped to 1..NUM_FIELDS-BASE_FIELD |
| busy_o | output | 1 | High from start acceptance until the mask is taken |
| cr_rd_en_o | output | 8 | One-hot condition-field read-enable |
| cr_rd_data_i | input | 4 | Field data, valid one cycle after the enable |
| mask_valid_o | output | 1 | Finished mask is available |
| mask_ready_i | input | 1 | Consumer takes the mask |
| mask_o | output | 8 | Predicate mask, bit i for element i |

## Verification
The bench runs every selector code over a register file that holds distinct patterns. A decoder that swaps a pair's bit index or polarity then yields a mask with the wrong bits. Lengths of 0, 1, an odd middle value, the maximum and above the maximum are all used. A wrong clamp shows up as the wrong number of reads and a wrong completion time, and stale upper mask bits would survive from an earlier full-length run. Start pulses and selector changes are held high during a run, which exposes a design that restarts or re-latches its condition. Ready is delayed by several cycles to show a mask that drifts or a handshake that drops early.

// File: rtl/crpm_pkg.sv
package crpm_pkg;

    // Width of one condition field and of the selector code
    localparam int CR_FIELD_W = 4;
    localparam int COND_SEL_W = 3;
    localparam int BIT_SEL_W  = $clog2(CR_FIELD_W);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_CAP  = 2'd2,
        ST_DONE = 2'd3
    } crpm_state_e;

    // Decoded condition: which field bit, and whether to flip it
    typedef struct packed {
        logic [BIT_SEL_W-1:0] bit_sel;
        logic                 invert;
    } cond_ctl_t;

    // Pairs of codes share a bit; the low code bit sets polarity
    function automatic cond_ctl_t decode_cond(input logic [COND_SEL_W-1:0] sel);
        cond_ctl_t c;
        c.bit_sel = sel[COND_SEL_W-1:1];
        c.invert  = sel[0];
        return c;
    endfunction

endpackage

// File: rtl/crpm_cond_decode.sv
module crpm_cond_decode
    import crpm_pkg::*;
(
    input  logic [COND_SEL_W-1:0] sel_i,
    output cond_ctl_t             ctl_o
);

    always_comb begin
        ctl_o = decode_cond(sel_i);
    end

endmodule

// File: rtl/crpm_field_select.sv
module crpm_field_select #(
    parameter int NUM_FIELDS = 8,
    parameter int BASE_FIELD = 0,
    parameter int IDX_W      = 3
) (
    input  logic                  req_i,
    input  logic [IDX_W-1:0]      elem_idx_i,
    output logic [NUM_FIELDS-1:0] rd_en_o
);

    // Field numbers count down from the top enable bit
    for (genvar b = 0; b < NUM_FIELDS; b++) begin : g_en
        always_comb begin
            rd_en_o[b] = req_i &&
                ((int'(elem_idx_i) + BASE_FIELD) == (NUM_FIELDS - 1 - b));
        end
    end

endmodule

// File: rtl/crpm_mask_accum.sv
module crpm_mask_accum #(
    parameter int MASK_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic              wr_bit_i,
    output logic [MASK_W-1:0] mask_o
);

    for (genvar b = 0; b < MASK_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clear_i) begin
                mask_o[b] <= 1'b0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(b))) begin
                mask_o[b] <= wr_bit_i;
            end
        end
    end

endmodule

// File: rtl/cr_pred_mask_builder.sv
module cr_pred_mask_builder
    import crpm_pkg::*;
#(
    parameter  int NUM_FIELDS = 8,
    parameter  int BASE_FIELD = 0,
    localparam int MAX_LEN    = NUM_FIELDS - BASE_FIELD,
    localparam int LEN_W      = $clog2(NUM_FIELDS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [COND_SEL_W-1:0] cond_sel_i,
    input  logic [LEN_W-1:0]      vec_len_i,
    output logic                  busy_o,
    output logic [NUM_FIELDS-1:0] cr_rd_en_o,
    input  logic [CR_FIELD_W-1:0] cr_rd_data_i,
    output logic                  mask_valid_o,
    input  logic                  mask_ready_i,
    output logic [MAX_LEN-1:0]    mask_o
);

    localparam int IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    crpm_state_e      state_q;
    logic [IDX_W-1:0] elem_idx_q;
    logic [IDX_W-1:0] last_idx_q;
    cond_ctl_t        cond_q;

    cond_ctl_t        cond_d;
    logic [LEN_W-1:0] len_eff;
    logic [IDX_W-1:0] last_idx_d;
    logic             accept;
    logic             cap_fire;
    logic             pick_bit;

    crpm_cond_decode u_dec (
        .sel_i (cond_sel_i),
        .ctl_o (cond_d)
    );

    // Clamp the requested length into the legal range
    always_comb begin
        if (vec_len_i == '0) begin
            len_eff = LEN_W'(1);
        end else if (vec_len_i > LEN_W'(MAX_LEN)) begin
            len_eff = LEN_W'(MAX_LEN);
        end else begin
            len_eff = vec_len_i;
        end
        last_idx_d = IDX_W'(len_eff - LEN_W'(1));
    end

    assign accept   = (state_q == ST_IDLE) && start_i;
    assign cap_fire = (state_q == ST_CAP);
    assign pick_bit = cr_rd_data_i[cond_q.bit_sel] ^ cond_q.invert;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            elem_idx_q <= '0;
            last_idx_q <= '0;
            cond_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cond_q     <= cond_d;
                        last_idx_q <= last_idx_d;
                        elem_idx_q <= '0;
                        state_q    <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    state_q <= ST_CAP;
                end
                ST_CAP: begin
                    if (elem_idx_q == last_idx_q) begin
                        state_q <= ST_DONE;
                    end else begin
                        elem_idx_q <= elem_idx_q + IDX_W'(1);
                        state_q    <= ST_REQ;
                    end
                end
                ST_DONE: begin
                    if (mask_ready_i) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    crpm_field_select #(
        .NUM_FIELDS (NUM_FIELDS),
        .BASE_FIELD (BASE_FIELD),
        .IDX_W      (IDX_W)
    ) u_sel (
        .req_i      (state_q == ST_REQ),
        .elem_idx_i (elem_idx_q),
        .rd_en_o    (cr_rd_en_o)
    );

    crpm_mask_accum #(
        .MASK_W (MAX_LEN),
        .IDX_W  (IDX_W)
    ) u_mask (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (accept),
        .wr_en_i  (cap_fire),
        .wr_idx_i (elem_idx_q),
        .wr_bit_i (pick_bit),
        .mask_o   (mask_o)
    );

    assign busy_o       = (state_q != ST_IDLE);
    assign mask_valid_o = (state_q == ST_DONE);

endmodule

// File: rtl/crpm_checker.sv
module crpm_checker #(
    parameter int NUM_FIELDS = 8,
    parameter int MASK_W     = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start_i,
    input logic                  busy_o,
    input logic [NUM_FIELDS-1:0] cr_rd_en_o,
    input logic                  mask_valid_o,
    input logic                  mask_ready_i,
    input logic [MASK_W-1:0]     mask_o
);

    // R3
    rd_en_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cr_rd_en_o));

    // R3
    rd_en_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cr_rd_en_o != '0) |=> (cr_rd_en_o == '0));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o);

    // R9
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_valid_o && !mask_ready_i) |=> (mask_valid_o && $stable(mask_o)));

    // R9
    release_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_valid_o && mask_ready_i) |=> (!busy_o && !mask_valid_o));

    // R9
    valid_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mask_valid_o |-> busy_o);

    // R3
    no_read_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (cr_rd_en_o == '0));

endmodule

bind cr_pred_mask_builder crpm_checker #(
    .NUM_FIELDS (NUM_FIELDS),
    .MASK_W     (MAX_LEN)
) u_crpm_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .cr_rd_en_o   (cr_rd_en_o),
    .mask_valid_o (mask_valid_o),
    .mask_ready_i (mask_ready_i),
    .mask_o       (mask_o)
);

// File: tb/cr_pred_mask_builder_test.sv
`timescale 1ns/1ps
module cr_pred_mask_builder_test;

    localparam int NF   = 8;
    localparam int BASE = 0;
    localparam int MAXL = NF - BASE;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [2:0] cond_sel_i = '0;
    logic [3:0] vec_len_i = '0;
    logic       busy_o;
    logic [7:0] cr_rd_en_o;
    logic [3:0] cr_rd_data_i = '0;
    logic       mask_valid_o;
    logic       mask_ready_i = 1'b0;
    logic [7:0] mask_o;

    logic [3:0] cr_file [NF];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    cr_pred_mask_builder #(.NUM_FIELDS(NF), .BASE_FIELD(BASE)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .cond_sel_i(cond_sel_i),
        .vec_len_i(vec_len_i), .busy_o(busy_o), .cr_rd_en_o(cr_rd_en_o),
        .cr_rd_data_i(cr_rd_data_i), .mask_valid_o(mask_valid_o),
        .mask_ready_i(mask_ready_i), .mask_o(mask_o)
    );

    // Behavioural register file: one-cycle read of the addressed field
    always @(posedge clk) begin
        logic [3:0] d;
        d = '0;
        for (int b = 0; b < NF; b++) if (cr_rd_en_o[b]) d = cr_file[NF-1-b];
        cr_rd_data_i <= d;
    end

    // Reference model: phase 0 idle, 1 request, 2 capture, 3 done
    int         m_phase = 0;
    int         m_idx = 0;
    int         m_len = 1;
    int         m_sel = 0;
    logic [7:0] m_mask = '0;

    function automatic int clamp_len(input int v);
        if (v < 1) return 1;
        if (v > MAXL) return MAXL;
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase <= 0; m_idx <= 0; m_mask <= '0;
        end else begin
            case (m_phase)
                0: if (start_i) begin
                    m_phase <= 1; m_idx <= 0; m_mask <= '0;
                    m_sel <= int'(cond_sel_i);
                    m_len <= clamp_len(int'(vec_len_i));
                end
                1: m_phase <= 2;
                2: begin
                    m_mask[m_idx] <= cr_file[m_idx+BASE][m_sel/2] ^ m_sel[0];
                    if (m_idx == m_len - 1) m_phase <= 3;
                    else begin m_idx <= m_idx + 1; m_phase <= 1; end
                end
                default: if (mask_ready_i) m_phase <= 0;
            endcase
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check("R2 busy", int'(busy_o), int'(m_phase != 0));
            check("R3 R4 rd_en", int'(cr_rd_en_o),
                  (m_phase == 1) ? (1 << (NF-1-(m_idx+BASE))) : 0);
            check("R9 valid", int'(mask_valid_o), int'(m_phase == 3));
            check("R5 R6 R7 mask", int'(mask_o), int'(m_mask));
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<=150000", cycles);
                finish_run();
            end
        end
    end

    // One run: start, optional noise while busy, delayed ready
    task automatic run(input int sel, input int len, input int rdy_delay,
                       input bit noise, input string req);
        int eff;
        int cnt;
        logic [7:0] exp;
        eff = clamp_len(len);
        @(negedge clk);
        start_i = 1'b1; cond_sel_i = 3'(sel); vec_len_i = 4'(len);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (noise) begin
                start_i = 1'b1; cond_sel_i = 3'(sel ^ 1); vec_len_i = 4'(8 - eff + 1);
            end else begin
                start_i = 1'b0;
            end
        end while (!mask_valid_o);
        start_i = 1'b0;
        // R10: valid after 2*len edges past the accepting edge
        check({"R10 ", req}, cnt, 2*eff + 1);
        exp = '0;
        for (int i = 0; i < eff; i++) exp[i] = cr_file[i+BASE][sel/2] ^ sel[0];
        check({"R5 R6 R7 ", req}, int'(mask_o), int'(exp));
        for (int k = 0; k < rdy_delay; k++) @(negedge clk);
        // R9: mask unchanged while waiting
        check({"R9 hold ", req}, int'(mask_o), int'(exp));
        check({"R9 valid ", req}, int'(mask_valid_o), 1);
        mask_ready_i = 1'b1;
        @(negedge clk);
        mask_ready_i = 1'b0;
        check({"R9 idle ", req}, int'(busy_o), 0);
    endtask

    initial begin
        cr_file[0] = 4'b0001; cr_file[1] = 4'b0110;
        cr_file[2] = 4'b1010; cr_file[3] = 4'b1101;
        cr_file[4] = 4'b0011; cr_file[5] = 4'b1000;
        cr_file[6] = 4'b0100; cr_file[7] = 4'b1111;
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        check("R1 busy", int'(busy_o), 0);
        check("R1 valid", int'(mask_valid_o), 0);
        check("R1 rd_en", int'(cr_rd_en_o), 0);
        check("R1 mask", int'(mask_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after", int'(busy_o), 0);
        // R5 R6: every selector code at full length
        for (int s = 0; s < 8; s++) run(s, 8, s % 3, 1'b0, "all codes");
        // R7 R8: short lengths clear upper bits left from a full run
        run(7, 1, 0, 1'b0, "len1");
        run(1, 3, 2, 1'b0, "len3");
        run(4, 0, 0, 1'b0, "R8 len0");
        run(6, 15, 1, 1'b0, "R8 over");
        run(3, 9, 0, 1'b0, "R8 nine");
        // R2: start and selector changes while busy are ignored
        run(2, 5, 4, 1'b1, "R2 noise");
        run(5, 8, 1, 1'b1, "R2 noise full");
        // new field contents, back-to-back
        cr_file[0] = 4'b1110; cr_file[3] = 4'b0010; cr_file[7] = 4'b0000;
        run(0, 8, 0, 1'b0, "R3 R4 refresh");
        run(7, 4, 0, 1'b0, "R3 R4 refresh");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule